// File: doc/BRIEF.md
# Receiver Error Flag Aggregator

This block gathers the error conditions of a biphase-coded digital audio receiver and turns them into one combined error pin, a set of sticky status bits and the controls that mute or freeze the audio path. Parity, biphase and frame-length errors arrive as levels that are valid at each subframe strobe. Unlock arrives as a level from the clock-recovery loop. A sample-rate tick paces the hold timer and the status-change comparison, and two read strobes clear the sticky bits and the status-change flag.

The combined error pin is driven by a three-state hold machine. In `HS_IDLE` the pin is low. The transition `HS_IDLE -> HS_ACTIVE` is taken when any unmasked cause is present. The transition `HS_ACTIVE -> HS_HOLD` is taken when every cause has gone, and the hold counter is loaded at that point. `HS_HOLD -> HS_ACTIVE` is taken when a cause returns. `HS_HOLD -> HS_IDLE` is taken on the sample tick that ends the hold time. Any state goes to `HS_IDLE` while the loop is off.

The status-change detector is also a small machine. `CS_DISARMED` lasts from reset to the first block-start strobe (`CS_DISARMED -> CS_ARMED`). `CS_ARMED -> CS_FLAGGED` is taken on a tick where the status field has changed. `CS_FLAGGED -> CS_ARMED` is taken on a read of the status-change register with no new change in the same cycle.

Top module: `rx_err_agg`

## Requirements
- R1: `err_out` rises one clock after any cause becomes present while `pll_off` is low. The causes are `unlock`, the three current data errors and `stc_flag`.
- R2: `err_out` is low in every cycle in which `pll_off` is high. A clock edge with `pll_off` high returns the hold machine to idle, so `err_out` stays low afterwards until a cause appears again.
- R3: After the last cause clears, `err_out` stays high until the N-th `fs_tick` and is low after that tick. In serial mode (`serial_mode`=1), N = 512 << `hold_sel` (0:512, 1:1024, 2:2048, 3:4096). In parallel mode N is always 1024.
- R4: In serial mode, `mask_dat`=1 removes the parity, biphase and frame-length errors from `err_out`, and `mask_stc`=1 removes `stc_flag`. In parallel mode both masks are ignored and `stc_flag` never contributes.
- R5: The current parity, biphase and frame-length levels are taken from `par_err`, `bip_err` and `frm_err` only on cycles where `subfr_stb` is high, and they hold until the next strobe.
- R6: On an `fs_tick`, `stc_flag` sets when `status_in` differs from its value at the previous `fs_tick`. A change without a tick does not set it.
- R7: `stc_flag` cannot set before the first `blk_stb` after reset. It holds until `rd_stat_chg` is high. A change on the same cycle as that read keeps it set.
- R8: `stk_par`, `stk_bip`, `stk_frm` and `stk_v` set when the matching input is 1 on a `subfr_stb`. `stk_unlk` sets while `unlock` is 1. All five clear on `rd_stat_err` unless set again in the same cycle.
- R9: While `unlock` is 1, `dat_mute`, `v_low` and `cs_freeze` are 1.
- R10: `dat_hold` is 1 when any current data error is 1 and `unlock` is 0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_mode | input | 1 | 1 = serial control mode, 0 = parallel mode |
| pll_off | input | 1 | Clock-recovery loop is switched off |
| unlock | input | 1 | Loop unlocked level |
| subfr_stb | input | 1 | Subframe strobe qualifying the data errors |
| par_err | input | 1 | Parity error of the current subframe |
| bip_err | input | 1 | Biphase coding error of the current subframe |
| frm_err | input | 1 | Preamble interval error of the current subframe |
| v_in | input | 1 | Validity bit of the current subframe |
| fs_tick | input | 1 | One pulse per sample period |
| blk_stb | input | 1 | Block start strobe |
| status_in | input | 6 | Receiver status field compared for changes |
| mask_dat | input | 1 | Mask data errors from the error pin (serial mode) |
| mask_stc | input | 1 | Mask the status-change flag from the error pin (serial mode) |
| hold_sel | input | 2 | Hold length select (serial mode) |
| rd_stat_chg | input | 1 | Read strobe of the status-change register |
| rd_stat_err | input | 1 | Read strobe of the error status register |
| err_out | output | 1 | Combined error pin |
| stk_par | output | 1 | Sticky parity error |
| stk_bip | output | 1 | Sticky biphase error |
| stk_frm | output | 1 | Sticky frame-length error |
| stk_v | output | 1 | Sticky validity flag |
| stk_unlk | output | 1 | Sticky unlock flag |
| stc_flag | output | 1 | Status-change flag |
| dat_mute | output | 1 | Force audio data output low |
| dat_hold | output | 1 | Repeat previous audio sample |
| v_low | output | 1 | Force validity output low |
| cs_freeze | output | 1 | Freeze channel-status capture |

## Verification
A hold machine stuck in the wrong state shows on `err_out` one clock after a cause changes. A hold counter loaded with the wrong value only shows at the end of the hold window, up to 4096 ticks later. For that reason each hold length is swept tick by tick, with the pin checked after every tick. A status-change machine that arms too early shows as `stc_flag` rising on the first tick after reset. Sticky bits that are mis-sequenced against a read show in the cycle right after the read strobe.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;

    // States of the error pin hold machine
    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_ACTIVE = 2'd1,
        HS_HOLD   = 2'd2
    } hold_state_t;

    // States of the status-change detector
    typedef enum logic [1:0] {
        CS_DISARMED = 2'd0,
        CS_ARMED    = 2'd1,
        CS_FLAGGED  = 2'd2
    } stc_state_t;

    // Index of each sticky bit in the sampler vector
    localparam int STK_PAR  = 0;
    localparam int STK_BIP  = 1;
    localparam int STK_FRM  = 2;
    localparam int STK_V    = 3;
    localparam int STK_UNLK = 4;
    localparam int STK_NUM  = 5;

endpackage

// File: rtl/rx_err_sampler.sv
module rx_err_sampler
    import rx_err_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               subfr_stb,
    input  logic               par_err,
    input  logic               bip_err,
    input  logic               frm_err,
    input  logic               v_in,
    input  logic               unlock,
    input  logic               rd_clr,
    output logic               cur_par,
    output logic               cur_bip,
    output logic               cur_frm,
    output logic [STK_NUM-1:0] sticky
);

    logic [STK_NUM-1:0] set_ev;

    // Current subframe error levels, refreshed only on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_par <= 1'b0;
            cur_bip <= 1'b0;
            cur_frm <= 1'b0;
        end else if (subfr_stb) begin
            cur_par <= par_err;
            cur_bip <= bip_err;
            cur_frm <= frm_err;
        end
    end

    always_comb begin
        set_ev           = '0;
        set_ev[STK_PAR]  = subfr_stb & par_err;
        set_ev[STK_BIP]  = subfr_stb & bip_err;
        set_ev[STK_FRM]  = subfr_stb & frm_err;
        set_ev[STK_V]    = subfr_stb & v_in;
        set_ev[STK_UNLK] = unlock;
    end

    // One sticky cell per flag; a set event beats the clearing read
    for (genvar i = 0; i < STK_NUM; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sticky[i] <= 1'b0;
            end else if (set_ev[i]) begin
                sticky[i] <= 1'b1;
            end else if (rd_clr) begin
                sticky[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rx_err_stc.sv
module rx_err_stc
    import rx_err_pkg::*;
#(
    parameter int STAT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_tick,
    input  logic              blk_stb,
    input  logic [STAT_W-1:0] status_in,
    input  logic              rd_clr,
    output logic              stc_flag
);

    stc_state_t        st_q;
    stc_state_t        st_d;
    logic [STAT_W-1:0] prev_q;
    logic              change;

    assign change = fs_tick && (status_in != prev_q);

    // Previous sample of the status field, taken once per sample period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (fs_tick) begin
            prev_q <= status_in;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_DISARMED: if (blk_stb)            st_d = CS_ARMED;
            CS_ARMED:    if (change)             st_d = CS_FLAGGED;
            CS_FLAGGED:  if (rd_clr && !change)  st_d = CS_ARMED;
            default:                             st_d = CS_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CS_DISARMED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stc_flag = (st_q == CS_FLAGGED);
    end

endmodule

// File: rtl/rx_err_hold.sv
module rx_err_hold
    import rx_err_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pll_off,
    input  logic             cause,
    input  logic             fs_tick,
    input  logic [CNT_W-1:0] hold_len,
    output logic             err_out
);

    hold_state_t      state_q;
    hold_state_t      state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;

    assign last_tick = fs_tick && (cnt_q <= CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:   if (cause)      state_d = HS_ACTIVE;
            HS_ACTIVE: if (!cause)     state_d = HS_HOLD;
            HS_HOLD: begin
                if (cause)             state_d = HS_ACTIVE;
                else if (last_tick)    state_d = HS_IDLE;
            end
            default:                   state_d = HS_IDLE;
        endcase
        if (pll_off) state_d = HS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Remaining sample periods of the hold window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d == HS_HOLD && state_q != HS_HOLD) begin
            cnt_q <= hold_len;
        end else if (state_q == HS_HOLD && fs_tick && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        err_out = (state_q != HS_IDLE) && !pll_off;
    end

endmodule

// File: rtl/rx_err_agg.sv
module rx_err_agg
    import rx_err_pkg::*;
#(
    parameter int STAT_W    = 6,
    parameter int HOLD_BASE = 512,
    parameter int SEL_W     = 2,
    parameter int SEL_DFLT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_mode,
    input  logic              pll_off,
    input  logic              unlock,
    input  logic              subfr_stb,
    input  logic              par_err,
    input  logic              bip_err,
    input  logic              frm_err,
    input  logic              v_in,
    input  logic              fs_tick,
    input  logic              blk_stb,
    input  logic [STAT_W-1:0] status_in,
    input  logic              mask_dat,
    input  logic              mask_stc,
    input  logic [SEL_W-1:0]  hold_sel,
    input  logic              rd_stat_chg,
    input  logic              rd_stat_err,
    output logic              err_out,
    output logic              stk_par,
    output logic              stk_bip,
    output logic              stk_frm,
    output logic              stk_v,
    output logic              stk_unlk,
    output logic              stc_flag,
    output logic              dat_mute,
    output logic              dat_hold,
    output logic              v_low,
    output logic              cs_freeze
);

    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int CNT_W     = $clog2(HOLD_BASE << MAX_SHIFT) + 1;

    logic               cur_par;
    logic               cur_bip;
    logic               cur_frm;
    logic               cur_any;
    logic [STK_NUM-1:0] sticky;
    logic [SEL_W-1:0]   eff_sel;
    logic [CNT_W-1:0]   hold_len;
    logic               dat_cause;
    logic               stc_cause;
    logic               cause_any;

    rx_err_sampler u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .subfr_stb (subfr_stb),
        .par_err   (par_err),
        .bip_err   (bip_err),
        .frm_err   (frm_err),
        .v_in      (v_in),
        .unlock    (unlock),
        .rd_clr    (rd_stat_err),
        .cur_par   (cur_par),
        .cur_bip   (cur_bip),
        .cur_frm   (cur_frm),
        .sticky    (sticky)
    );

    rx_err_stc #(.STAT_W(STAT_W)) u_stc (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_tick   (fs_tick),
        .blk_stb   (blk_stb),
        .status_in (status_in),
        .rd_clr    (rd_stat_chg),
        .stc_flag  (stc_flag)
    );

    // Parallel mode has no masks, no hold select and no status-change cause
    assign cur_any   = cur_par | cur_bip | cur_frm;
    assign eff_sel   = serial_mode ? hold_sel : SEL_W'(SEL_DFLT);
    assign hold_len  = CNT_W'(HOLD_BASE) << eff_sel;
    assign dat_cause = cur_any & ~(serial_mode & mask_dat);
    assign stc_cause = stc_flag & serial_mode & ~mask_stc;
    assign cause_any = unlock | dat_cause | stc_cause;

    rx_err_hold #(.CNT_W(CNT_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .pll_off  (pll_off),
        .cause    (cause_any),
        .fs_tick  (fs_tick),
        .hold_len (hold_len),
        .err_out  (err_out)
    );

    assign stk_par   = sticky[STK_PAR];
    assign stk_bip   = sticky[STK_BIP];
    assign stk_frm   = sticky[STK_FRM];
    assign stk_v     = sticky[STK_V];
    assign stk_unlk  = sticky[STK_UNLK];

    // Audio path controls
    assign dat_mute  = unlock;
    assign v_low     = unlock;
    assign cs_freeze = unlock;
    assign dat_hold  = cur_any & ~unlock;

endmodule

// File: rtl/rx_err_agg_chk.sv
module rx_err_agg_chk (
    input logic clk,
    input logic rst_n,
    input logic pll_off,
    input logic unlock,
    input logic subfr_stb,
    input logic par_err,
    input logic fs_tick,
    input logic rd_stat_chg,
    input logic rd_stat_err,
    input logic cause_any,
    input logic err_out,
    input logic stk_par,
    input logic stc_flag,
    input logic dat_mute,
    input logic dat_hold,
    input logic v_low,
    input logic cs_freeze
);

    AST_PLL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pll_off |-> !err_out);                                   // R2

    AST_RISE_FROM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_out) |-> $past(cause_any));                    // R1

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_par && !rd_stat_err) |=> stk_par);                  // R8

    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_err && !(subfr_stb && par_err)) |=> !stk_par);  // R8

    AST_STC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stc_flag && !rd_stat_chg) |=> stc_flag);                // R7

    AST_STC_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!stc_flag && !fs_tick) |=> !stc_flag);                  // R6

    AST_UNLOCK_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |-> (dat_mute && v_low && cs_freeze && !dat_hold)); // R9

endmodule

bind rx_err_agg rx_err_agg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_off     (pll_off),
    .unlock      (unlock),
    .subfr_stb   (subfr_stb),
    .par_err     (par_err),
    .fs_tick     (fs_tick),
    .rd_stat_chg (rd_stat_chg),
    .rd_stat_err (rd_stat_err),
    .cause_any   (cause_any),
    .err_out     (err_out),
    .stk_par     (stk_par),
    .stc_flag    (stc_flag),
    .dat_mute    (dat_mute),
    .dat_hold    (dat_hold),
    .v_low       (v_low),
    .cs_freeze   (cs_freeze)
);

// File: tb/rx_err_agg_tb.sv
module rx_err_agg_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       serial_mode, pll_off, unlock, subfr_stb;
    logic       par_err, bip_err, frm_err, v_in, fs_tick, blk_stb;
    logic [5:0] status_in;
    logic       mask_dat, mask_stc;
    logic [1:0] hold_sel;
    logic       rd_stat_chg, rd_stat_err;
    logic       err_out, stk_par, stk_bip, stk_frm, stk_v, stk_unlk;
    logic       stc_flag, dat_mute, dat_hold, v_low, cs_freeze;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_err_agg u_dut (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .pll_off(pll_off),
        .unlock(unlock), .subfr_stb(subfr_stb), .par_err(par_err),
        .bip_err(bip_err), .frm_err(frm_err), .v_in(v_in), .fs_tick(fs_tick),
        .blk_stb(blk_stb), .status_in(status_in), .mask_dat(mask_dat),
        .mask_stc(mask_stc), .hold_sel(hold_sel), .rd_stat_chg(rd_stat_chg),
        .rd_stat_err(rd_stat_err), .err_out(err_out), .stk_par(stk_par),
        .stk_bip(stk_bip), .stk_frm(stk_frm), .stk_v(stk_v),
        .stk_unlk(stk_unlk), .stc_flag(stc_flag), .dat_mute(dat_mute),
        .dat_hold(dat_hold), .v_low(v_low), .cs_freeze(cs_freeze)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pll_pulse();
        pll_off = 1'b1;
        step();
        pll_off = 1'b0;
        step();
    endtask

    task automatic tick();
        fs_tick = 1'b1;
        step();
        fs_tick = 1'b0;
    endtask

    // R3: the pin must stay high through tick n-1 and be low after tick n
    task automatic run_hold(input int n);
        int   first_low = 0;
        logic last_v    = 1'b1;
        unlock = 1'b1;
        step();
        step();
        chk(err_out == 1'b1, "R1 unlock raises pin", int'(err_out), 1);
        unlock = 1'b0;
        step();
        fs_tick = 1'b1;
        for (int k = 1; k <= n; k++) begin
            step();
            if (k < n && !err_out && first_low == 0) first_low = k;
            last_v = err_out;
        end
        fs_tick = 1'b0;
        chk(first_low == 0, "R3 pin high until last tick", first_low, 0);
        chk(last_v == 1'b0, "R3 pin low after last tick", int'(last_v), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; serial_mode = 1'b1; pll_off = 1'b0; unlock = 1'b0;
        subfr_stb = 1'b0; par_err = 1'b0; bip_err = 1'b0; frm_err = 1'b0;
        v_in = 1'b0; fs_tick = 1'b0; blk_stb = 1'b0; status_in = 6'd0;
        mask_dat = 1'b1; mask_stc = 1'b1; hold_sel = 2'd1;
        rd_stat_chg = 1'b0; rd_stat_err = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // Reset state
        chk(err_out == 1'b0, "R1 reset pin", int'(err_out), 0);
        chk({stk_par, stk_bip, stk_frm, stk_v, stk_unlk} == 5'd0, "R8 reset sticky",
            int'({stk_par, stk_bip, stk_frm, stk_v, stk_unlk}), 0);
        chk(stc_flag == 1'b0, "R7 reset flag", int'(stc_flag), 0);

        // R9: unlock drives the mute controls
        unlock = 1'b1;
        #1;
        chk({dat_mute, v_low, cs_freeze} == 3'b111, "R9 unlock mutes",
            int'({dat_mute, v_low, cs_freeze}), 7);
        unlock = 1'b0;
        step();

        // R3: hold length sweep over every select in serial mode, then parallel
        for (int s = 0; s < 4; s++) begin
            hold_sel = 2'(s);
            run_hold(512 << s);
        end
        serial_mode = 1'b0;
        hold_sel = 2'd3;
        run_hold(1024);
        serial_mode = 1'b1;

        // R8: unlock sticky cleared by the error status read
        chk(stk_unlk == 1'b1, "R8 unlock sticky set", int'(stk_unlk), 1);
        rd_stat_err = 1'b1;
        step();
        rd_stat_err = 1'b0;
        chk(stk_unlk == 1'b0, "R8 unlock sticky cleared", int'(stk_unlk), 0);

        // R2: loop off forces the pin low at once and ends the hold
        unlock = 1'b1;
        step();
        step();
        unlock = 1'b0;
        step();
        chk(err_out == 1'b1, "R2 pin in hold", int'(err_out), 1);
        pll_off = 1'b1;
        #1;
        chk(err_out == 1'b0, "R2 pin low with loop off", int'(err_out), 0);
        step();
        pll_off = 1'b0;
        step();
        chk(err_out == 1'b0, "R2 hold abandoned", int'(err_out), 0);

        // R5: no strobe, no sample
        par_err = 1'b1;
        step();
        chk(stk_par == 1'b0 && dat_hold == 1'b0, "R5 error without strobe",
            int'({stk_par, dat_hold}), 0);
        subfr_stb = 1'b1;
        step();
        subfr_stb = 1'b0;
        par_err = 1'b0;
        chk(stk_par == 1'b1, "R8 parity sticky set", int'(stk_par), 1);
        chk(dat_hold == 1'b1, "R10 repeat on parity error", int'(dat_hold), 1);
        step();
        chk(err_out == 1'b0, "R4 data mask serial", int'(err_out), 0);
        mask_dat = 1'b0;
        step();
        chk(err_out == 1'b1, "R4 data unmasked", int'(err_out), 1);
        mask_dat = 1'b1;
        pll_pulse();
        chk(err_out == 1'b0, "R4 masked again", int'(err_out), 0);
        serial_mode = 1'b0;
        step();
        step();
        chk(err_out == 1'b1, "R4 parallel ignores mask", int'(err_out), 1);
        serial_mode = 1'b1;

        // R10/R9: unlock overrides repeat
        unlock = 1'b1;
        #1;
        chk(dat_hold == 1'b0 && dat_mute == 1'b1, "R10 unlock beats repeat",
            int'({dat_hold, dat_mute}), 1);
        unlock = 1'b0;
        subfr_stb = 1'b1;
        step();
        subfr_stb = 1'b0;
        chk(dat_hold == 1'b0, "R5 clean strobe clears level", int'(dat_hold), 0);
        pll_pulse();

        // R8: set beats clear, validity and frame sticky
        rd_stat_err = 1'b1;
        subfr_stb = 1'b1;
        bip_err = 1'b1;
        step();
        rd_stat_err = 1'b0;
        bip_err = 1'b0;
        chk(stk_par == 1'b0 && stk_bip == 1'b1, "R8 read versus set",
            int'({stk_par, stk_bip}), 1);
        v_in = 1'b1;
        frm_err = 1'b1;
        step();
        subfr_stb = 1'b0;
        v_in = 1'b0;
        frm_err = 1'b0;
        chk(stk_v == 1'b1 && stk_frm == 1'b1, "R8 validity and frame",
            int'({stk_v, stk_frm}), 3);
        rd_stat_err = 1'b1;
        step();
        rd_stat_err = 1'b0;
        chk({stk_par, stk_bip, stk_frm, stk_v} == 4'd0, "R8 all cleared",
            int'({stk_par, stk_bip, stk_frm, stk_v}), 0);
        subfr_stb = 1'b1;
        step();
        subfr_stb = 1'b0;
        pll_pulse();

        // R6/R7: status change detection
        status_in = 6'd5;
        tick();
        chk(stc_flag == 1'b0, "R7 suppressed before block", int'(stc_flag), 0);
        blk_stb = 1'b1;
        step();
        blk_stb = 1'b0;
        tick();
        chk(stc_flag == 1'b0, "R6 same value no flag", int'(stc_flag), 0);
        status_in = 6'd6;
        step();
        chk(stc_flag == 1'b0, "R6 change without tick", int'(stc_flag), 0);
        tick();
        chk(stc_flag == 1'b1, "R6 change on tick", int'(stc_flag), 1);
        rd_stat_chg = 1'b1;
        step();
        rd_stat_chg = 1'b0;
        chk(stc_flag == 1'b0, "R7 read clears", int'(stc_flag), 0);
        status_in = 6'd7;
        rd_stat_chg = 1'b1;
        tick();
        rd_stat_chg = 1'b0;
        chk(stc_flag == 1'b1, "R7 change beats read", int'(stc_flag), 1);
        step();
        chk(err_out == 1'b0, "R4 change flag masked", int'(err_out), 0);
        serial_mode = 1'b0;
        mask_stc = 1'b0;
        step();
        step();
        chk(err_out == 1'b0, "R4 parallel excludes change flag", int'(err_out), 0);
        serial_mode = 1'b1;
        step();
        chk(err_out == 1'b1, "R1 change flag raises pin", int'(err_out), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule